// File: doc/BRIEF.md
# Dual-Port Ordered Packet Ingress with Flow-Unit Packing

This block takes transaction packets from an application over six ingress ports: two for each of the three flow-control classes (Posted, Non-Posted, Completion). Both ports of one class may hand over a packet in the same cycle. At the moment of acceptance, every packet is given a sequence number that counts separately for each class. The packet is then written into a queue owned by its class. Packets within one class therefore keep their order, whichever port they came in on. The three classes do not wait on one another.

A round-robin merge picks the next packet from one of the classes that has a packet waiting. A packer then writes each chosen packet as one header byte followed by its payload bytes. The packets are placed back to back, one byte per cycle, into fixed flow units of `FU_BYTES` bytes (256 by default). A packet may run past the end of a unit and carry on into the next one. When the packer reaches a packet boundary and no packet is waiting, it fills the rest of the unit with zero bytes.

Top module: `tlp_mstream_ingress`

## Requirements
- R1: Each class (index 0 = Posted, 1 = Non-Posted, 2 = Completion) has two ports. Lane `2*class+port` of `in_valid`/`in_ready` and slice `lane*PKT_BYTES*8` of `in_data` belong to that port. Both ports of a class can be accepted in the same cycle.
- R2: An accepted packet leaves with a header byte. Bits [7:6] hold the class code (Posted=1, Non-Posted=2, Completion=3). Bits [ORD_W-1:0] hold its class sequence number. The remaining bits are 0. The sequence starts at 0 after reset. When both ports of a class are accepted together, port 0 gets the lower number.
- R3: The sequence number counts modulo 2^ORD_W (16 by default) and wraps from 15 to 0.
- R4: Packets of one class leave in sequence-number order, with the payload unchanged.
- R5: Port 0 of a class is ready while that class queue holds fewer than `DEPTH` packets. Port 1 is ready while it holds fewer than `DEPTH-1`. No accepted packet is lost or repeated.
- R6: A class with nothing queued never delays the others. A newly queued class is served no later than the second packet after it arrives.
- R7: The merge grants classes in round-robin order, and Posted has first turn after reset. When all three classes stay loaded, the output class order is Posted, Non-Posted, Completion, repeating.
- R8: A packet goes out as its header byte followed by `PKT_BYTES` payload bytes, least significant byte first, on consecutive valid cycles.
- R9: Output is grouped into units of `FU_BYTES` bytes. `out_sof` marks the first byte of each unit, the bytes of a unit come on consecutive cycles, and every started unit is completed.
- R10: Once the packer reaches a packet boundary inside a unit and no packet is waiting, it sends 0x00 to the end of that unit, and no packet starts before the next unit.
- R11: A packet that does not fit in the rest of a unit continues with its remaining bytes at the start of the next unit.
- R12: During reset `out_valid` is low and all six `in_ready` bits are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 6 | Packet offered, one bit per class port |
| in_data | input | 6*PKT_BYTES*8 | Packet payloads, one slice per class port |
| in_ready | output | 6 | Port can accept this cycle |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | First byte of a flow unit |
| out_byte | output | 8 | Output byte of the merged stream |

## Verification
The assertions assume that a port's offered payload is stable while it is offered in a cycle. They also assume that `ORD_W` is no more than six, so the sequence number fits under the class code in the header byte. The stimulus changes inputs only on the falling edge and reads `in_ready` before the rising edge, so acceptance is decided only by ready and valid. A packet that is refused is simply withdrawn, never counted as sent. The header byte of a real packet is never zero because the class codes start at 1, so the bench can separate packets from padding by looking at the first byte at each packet boundary.

// File: rtl/tlp_ms_pkg.sv
package tlp_ms_pkg;
  localparam int NUM_CLS = 3;
  localparam int PORTS_PER_CLS = 2;
  localparam int NUM_LANES = NUM_CLS * PORTS_PER_CLS;
  localparam int HDR_ORD_MAX = 6;

  function automatic logic [1:0] cls_code(input int unsigned idx);
    return 2'(idx + 1);
  endfunction
endpackage

// File: rtl/tlp_ord_queue.sv
module tlp_ord_queue #(
  parameter int PKT_W = 96,
  parameter int ORD_W = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       in_vld,
  input  logic [PKT_W-1:0] in_d0,
  input  logic [PKT_W-1:0] in_d1,
  output logic [1:0]       in_rdy,
  input  logic             pop,
  output logic             avail,
  output logic [PKT_W-1:0] head_data,
  output logic [ORD_W-1:0] head_ord
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = PKT_W + ORD_W;

  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_n, rp_q, rp_n, wp1;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [ORD_W-1:0] ord_q, ord_n;
  logic             acc0, acc1, do_pop;

  always_comb begin
    in_rdy[0] = cnt_q < CW'(DEPTH);
    in_rdy[1] = cnt_q < CW'(DEPTH - 1);
    acc0      = in_vld[0] & in_rdy[0];
    acc1      = in_vld[1] & in_rdy[1];
    avail     = cnt_q != '0;
    do_pop    = pop & avail;
    wp1       = wp_q + AW'(acc0);
    wp_n      = wp1 + AW'(acc1);
    rp_n      = rp_q + AW'(do_pop);
    cnt_n     = cnt_q + CW'(acc0) + CW'(acc1) - CW'(do_pop);
    ord_n     = ord_q + ORD_W'(acc0) + ORD_W'(acc1);
  end

  always_ff @(posedge clk) begin
    if (acc0) mem[wp_q] <= {ord_q, in_d0};
    if (acc1) mem[wp1]  <= {ord_q + ORD_W'(acc0), in_d1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ord_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      ord_q <= ord_n;
    end
  end

  assign {head_ord, head_data} = mem[rp_q];

  logic             seen_q;
  logic [ORD_W-1:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (do_pop) seen_q <= 1'b1;
  end
  always_ff @(posedge clk) begin
    if (do_pop) last_q <= head_ord;
  end

  assert_pop_in_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && seen_q) |-> (head_ord == last_q + ORD_W'(1)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_first_ord_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !seen_q) |-> (head_ord == '0));
endmodule

// File: rtl/tlp_merge_rr.sv
module tlp_merge_rr #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] prio_q, prio_n;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    any     = |req;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(prio_q) + k;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        found   = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
    prio_n = prio_q;
    if (take && any) prio_n = (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= prio_n;
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_idle_class_no_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((gnt & req) != '0));
  assert_rr_moves_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && any && $countones(req) > 1) |=> (gnt_idx != $past(gnt_idx) || !any));
endmodule

// File: rtl/tlp_flow_packer.sv
module tlp_flow_packer #(
  parameter int PKT_BYTES = 12,
  parameter int ORD_W     = 4,
  parameter int FU_BYTES  = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   avail,
  input  logic [PKT_BYTES*8-1:0] pkt_data,
  input  logic [ORD_W-1:0]       pkt_ord,
  input  logic [1:0]             pkt_code,
  output logic                   take,
  output logic                   o_valid,
  output logic                   o_sof,
  output logic [7:0]             o_byte
);
  localparam int PKT_W = PKT_BYTES * 8;
  localparam int PW    = $clog2(FU_BYTES);
  localparam int RW    = $clog2(PKT_BYTES + 1);

  logic [PW-1:0]    pos_q, pos_n;
  logic [RW-1:0]    rem_q, rem_n;
  logic [PKT_W-1:0] sh_q, sh_n;
  logic             unit_q, unit_n, pad_q, pad_n;
  logic             emit, sof;
  logic [7:0]       byte_n;
  logic             ov_q, os_q;
  logic [7:0]       ob_q;

  always_comb begin
    emit   = 1'b0;
    take   = 1'b0;
    byte_n = 8'h00;
    sh_n   = sh_q;
    rem_n  = rem_q;
    pad_n  = pad_q;
    unit_n = unit_q;
    pos_n  = pos_q;
    if (rem_q != '0) begin
      emit   = 1'b1;
      byte_n = sh_q[7:0];
      sh_n   = sh_q >> 8;
      rem_n  = rem_q - RW'(1);
    end else if (avail && !pad_q) begin
      take   = 1'b1;
      emit   = 1'b1;
      byte_n = {pkt_code, 6'(pkt_ord)};
      sh_n   = pkt_data;
      rem_n  = RW'(PKT_BYTES);
    end else if (unit_q) begin
      emit   = 1'b1;
      pad_n  = 1'b1;
    end
    if (emit) begin
      if (pos_q == PW'(FU_BYTES - 1)) begin
        pos_n  = '0;
        unit_n = 1'b0;
        pad_n  = 1'b0;
      end else begin
        pos_n  = pos_q + PW'(1);
        unit_n = 1'b1;
      end
    end
    sof = emit & ~unit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      rem_q  <= '0;
      unit_q <= 1'b0;
      pad_q  <= 1'b0;
      ov_q   <= 1'b0;
      os_q   <= 1'b0;
      ob_q   <= 8'h00;
    end else begin
      pos_q  <= pos_n;
      rem_q  <= rem_n;
      unit_q <= unit_n;
      pad_q  <= pad_n;
      ov_q   <= emit;
      os_q   <= sof;
      ob_q   <= byte_n;
    end
  end

  always_ff @(posedge clk) begin
    if (emit) sh_q <= sh_n;
  end

  assign o_valid = ov_q;
  assign o_sof   = os_q;
  assign o_byte  = ob_q;

  assert_unit_contiguous_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_q |-> emit);
  assert_sof_at_unit_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !unit_q) |-> (pos_q == '0));
  assert_pad_to_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pad_q |-> !take);
  assert_packet_contiguous_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0) |-> emit);
endmodule

// File: rtl/tlp_mstream_ingress.sv
module tlp_mstream_ingress
  import tlp_ms_pkg::*;
#(
  parameter int PKT_BYTES = 12,
  parameter int ORD_W     = 4,
  parameter int DEPTH     = 8,
  parameter int FU_BYTES  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [5:0]               in_valid,
  input  logic [6*PKT_BYTES*8-1:0] in_data,
  output logic [5:0]               in_ready,
  output logic                     out_valid,
  output logic                     out_sof,
  output logic [7:0]               out_byte
);
  localparam int PKT_W = PKT_BYTES * 8;
  localparam int IW    = 2;

  logic [NUM_CLS-1:0] avail, gnt;
  logic [IW-1:0]      gnt_idx;
  logic               any, take;
  logic [PKT_W-1:0]   hd [NUM_CLS];
  logic [ORD_W-1:0]   ho [NUM_CLS];
  logic [PKT_W-1:0]   sel_data;
  logic [ORD_W-1:0]   sel_ord;
  logic [1:0]         sel_code;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    tlp_ord_queue #(.PKT_W(PKT_W), .ORD_W(ORD_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (in_valid[2*c +: 2]),
      .in_d0     (in_data[(2*c)*PKT_W +: PKT_W]),
      .in_d1     (in_data[(2*c+1)*PKT_W +: PKT_W]),
      .in_rdy    (in_ready[2*c +: 2]),
      .pop       (take & gnt[c]),
      .avail     (avail[c]),
      .head_data (hd[c]),
      .head_ord  (ho[c])
    );
  end

  tlp_merge_rr #(.N(NUM_CLS), .IW(IW)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (avail),
    .take    (take),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (any)
  );

  always_comb begin
    sel_data = '0;
    sel_ord  = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (gnt[c]) begin
        sel_data = hd[c];
        sel_ord  = ho[c];
      end
    end
    sel_code = cls_code(int'(gnt_idx));
  end

  tlp_flow_packer #(.PKT_BYTES(PKT_BYTES), .ORD_W(ORD_W), .FU_BYTES(FU_BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .avail    (any),
    .pkt_data (sel_data),
    .pkt_ord  (sel_ord),
    .pkt_code (sel_code),
    .take     (take),
    .o_valid  (out_valid),
    .o_sof    (out_sof),
    .o_byte   (out_byte)
  );

  assert_take_has_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $onehot(gnt));
  assert_hdr_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ORD_W <= HDR_ORD_MAX);
endmodule

// File: tb/tlp_mstream_ingress_bench.sv
`timescale 1ns/1ps
module tlp_mstream_ingress_bench;
  localparam int PB  = 12;
  localparam int PKW = PB * 8;
  localparam int HB  = PB + 1;
  localparam int FU  = 256;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [5:0]      in_valid;
  logic [6*PKW-1:0] in_data;
  logic [5:0]      in_ready;
  logic            out_valid, out_sof;
  logic [7:0]      out_byte;

  always #10 clk = ~clk;

  tlp_mstream_ingress u_tlp_mstream_ingress (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof), .out_byte(out_byte)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [HB*8-1:0] q_p[$], q_np[$], q_c[$];
  int seq_log[$];
  int ordc[3];
  int pseq = 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_push(input int c, input logic [HB*8-1:0] v);
    case (c)
      0: q_p.push_back(v);
      1: q_np.push_back(v);
      default: q_c.push_back(v);
    endcase
  endtask

  task automatic drive(input logic [5:0] vld, output logic [5:0] acc);
    logic [PKW-1:0] pl [6];
    @(negedge clk);
    for (int l = 0; l < 6; l++) begin
      pl[l] = {32'(pseq + l), 32'(l), 32'hA5000000 ^ 32'((pseq + l) * 7)};
      in_data[l*PKW +: PKW] = pl[l];
    end
    in_valid = vld;
    #1;
    acc = vld & in_ready;
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 2; p++) begin
        if (acc[2*c+p]) begin
          exp_push(c, {pl[2*c+p], 2'(c + 1), 6'(ordc[c] % 16)});
          ordc[c]++;
        end
      end
    end
    pseq += 6;
    @(posedge clk);
    #1 in_valid = '0;
  endtask

  // monitor: parses the byte stream and pops the scoreboard
  int pos = 0, bi = 0, pad_cnt = 0, last_pad = -1, span_cnt = 0, total = 0;
  bit pad_mode = 0, spanned = 0;
  logic [HB*8-1:0] cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        total++;
        if (out_sof != (pos == 0)) chk(0, "R9 sof position", 128'(out_sof), 128'(pos == 0));
        if (pad_mode) begin
          pad_cnt++;
          if (out_byte != 8'h00) chk(0, "R10 pad byte", 128'(out_byte), 128'h0);
        end else if (bi == 0) begin
          if (out_byte == 8'h00) begin
            pad_mode = 1;
            pad_cnt++;
          end else begin
            cur = '0;
            cur[7:0] = out_byte;
            bi = 1;
            spanned = 0;
          end
        end else begin
          cur[bi*8 +: 8] = out_byte;
          if (pos == 0) spanned = 1;
          bi++;
          if (bi == HB) begin
            int c;
            logic [HB*8-1:0] e;
            bi = 0;
            if (spanned) span_cnt++;
            c = int'(cur[7:6]) - 1;
            seq_log.push_back(c + 1);
            e = '0;
            case (c)
              0: if (q_p.size() > 0) e = q_p.pop_front();
              1: if (q_np.size() > 0) e = q_np.pop_front();
              default: if (q_c.size() > 0) e = q_c.pop_front();
            endcase
            chk(cur == e, "R2 R3 R4 R5 R8 packet", 128'(cur), 128'(e));
          end
        end
        pos = (pos == FU - 1) ? 0 : pos + 1;
        if (pos == 0) begin
          pad_mode = 0;
          last_pad = pad_cnt;
          pad_cnt = 0;
        end
      end else begin
        if (pos != 0) chk(0, "R9 gap inside unit", 128'(pos), 128'h0);
        if (bi != 0) chk(0, "R8 gap inside packet", 128'(bi), 128'h0);
      end
    end
  end

  task automatic wait_drain();
    int t = 0;
    while ((q_p.size() + q_np.size() + q_c.size()) != 0 && t < 20000) begin
      @(posedge clk);
      t++;
    end
    repeat (FU + 20) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 128'h0, 128'h1);
    finish_run();
  end

  initial begin
    logic [5:0] acc;
    bit saw1, saw0, rule_ok;
    int np_at;
    rst_n = 1'b0;
    in_valid = '0;
    in_data = '0;
    for (int c = 0; c < 3; c++) ordc[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 out_valid in reset", 128'(out_valid), 128'h0);
    chk(in_ready == 6'h3f, "R12 ready in reset", 128'(in_ready), 128'h3f);
    rst_n = 1'b1;

    // R1 / R7: all six ports for four cycles, all classes stay loaded
    seq_log.delete();
    drive(6'h3f, acc);
    chk(acc == 6'h3f, "R1 six accepts in one cycle", 128'(acc), 128'h3f);
    repeat (3) drive(6'h3f, acc);
    wait_drain();
    rule_ok = (seq_log.size() == 24);
    for (int i = 0; i < seq_log.size(); i++) if (seq_log[i] != (i % 3) + 1) rule_ok = 0;
    chk(rule_ok, "R7 round-robin class order", 128'(seq_log.size()), 128'd24);
    chk(span_cnt > 0, "R11 packet spans unit boundary", 128'(span_cnt), 128'h1);

    // R10: lone packet, rest of unit is padding
    drive(6'b000001, acc);
    repeat (FU + 40) @(posedge clk);
    chk(last_pad == FU - HB, "R10 pad count of lone packet", 128'(last_pad), 128'(FU - HB));

    // R3: Completion class through the wrap of the sequence number
    for (int i = 0; i < 24; i++) begin
      logic [1:0] pr;
      pr = (i % 3 == 0) ? 2'b10 : ((i % 3 == 1) ? 2'b11 : 2'b01);
      drive({pr, 4'b0000}, acc);
      repeat (6) @(posedge clk);
    end
    wait_drain();
    chk(ordc[2] > 16, "R3 wrap exercised", 128'(ordc[2]), 128'd17);

    // R5: fill the Posted queue
    saw1 = 0; saw0 = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!in_ready[0] && in_ready[1]) chk(0, "R5 port1 ready without port0", 128'(in_ready), 128'h0);
      if (!in_ready[1]) saw1 = 1;
      if (!in_ready[0]) saw0 = 1;
      drive(6'b000011, acc);
    end
    chk(saw1 && saw0, "R5 ready drops when full", 128'({saw1, saw0}), 128'h3);

    // R6: Non-Posted served promptly while Posted is backed up
    seq_log.delete();
    drive(6'b000100, acc);
    wait_drain();
    np_at = -1;
    for (int i = 0; i < seq_log.size(); i++) if (np_at < 0 && seq_log[i] == 2) np_at = i;
    chk(np_at >= 0 && np_at <= 1, "R6 non-posted not held back", 128'(np_at), 128'h1);
    chk(total % FU == 0, "R9 units complete", 128'(total % FU), 128'h0);
    finish_run();
  end
endmodule